// File: doc/BRIEF.md
# Single-Operand Accumulator Datapath

This block is the execute datapath of a small 8-bit machine in which every instruction names at most one operand. The accumulator is the implied second source and destination of the arithmetic and logic group. Six general byte registers also pair up as three 16-bit registers. A separate 16-bit stack pointer joins them as a fourth pair. A three-bit flag register records carry, zero and sign. An external sequencer presents one already-decoded operation per cycle with `op_valid`, together with an operand selector, a pair selector and the immediates. Every architectural result is visible at the block's registered outputs on the following cycle.

One operand choice is the byte in memory whose address sits in the H:L pair. The block always drives H:L on `mem_addr`. It reads the byte from `mem_rdata` in the cycle of the operation. When an operation writes that byte, the block pulses a one-cycle write strobe with the data. Fetch, opcode decoding, branching and stack sequencing sit outside this block.

Top module: `acc_datapath`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, all six byte registers, the stack pointer and the flags are cleared, and `mem_we` is low. After reset, `acc_out`, `flags_out` and `mem_addr` read zero.
- R2: `op_sel` codes 0..5 pick byte registers B, C, D, E, H, L, code 6 picks the memory byte at H:L, and code 7 picks the accumulator. OP_ADD, OP_SUB, OP_AND, OP_OR and OP_XOR combine the accumulator with the selected byte. The result appears on `acc_out` one cycle after the operation.
- R3: OP_CMP and OP_CMPI compute accumulator minus operand and write only the flags. The accumulator keeps its value.
- R4: `flags_out` bit 2 is sign (result bit 7), bit 1 is zero, and bit 0 is carry. Add sets carry on carry out of bit 7. Subtract and compare set carry when the operand is greater than the accumulator as unsigned values. AND, OR and XOR clear carry.
- R5: OP_ADDI, OP_SUBI, OP_ANDI, OP_ORI, OP_XORI and OP_CMPI behave like their register forms, with `imm8` as the operand.
- R6: OP_INC and OP_DEC add or subtract one in place on the selected operand, wrapping modulo 256. They update sign and zero from the result and leave carry unchanged.
- R7: OP_MOVI writes `imm8` into the selected operand and leaves the flags unchanged.
- R8: `op_pair` codes 0..3 pick BC, DE, HL and SP, with B, D and H as high bytes. OP_PINC and OP_PDEC step the pair by one, wrapping modulo 65536. OP_PLOAD loads `imm16`. None of the three alters the flags.
- R9: OP_PADD sets H:L to H:L plus the selected pair, modulo 65536. Carry takes the carry out of bit 15, and sign and zero are kept.
- R10: OP_ROTL rotates the accumulator left by one, and OP_ROTR rotates it right by one. The bit moved across the end goes both into the vacated position and into carry. Sign and zero are kept.
- R11: OP_SWAP exchanges the H:L pair with the D:E pair and leaves the flags unchanged.
- R12: OP_INC, OP_DEC and OP_MOVI with `op_sel` = 6 raise `mem_we` for exactly the next cycle. `mem_wdata` then carries the new byte and `mem_addr` still holds H:L. No other operation raises `mem_we`.
- R13: A cycle with `op_valid` low changes no register, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Decoded operation (package `acc_pkg` codes) |
| op_sel | input | 3 | Byte operand selector |
| op_pair | input | 2 | Register pair selector |
| imm8 | input | 8 | Byte immediate |
| imm16 | input | 16 | Word immediate |
| mem_rdata | input | 8 | Byte stored at `mem_addr` |
| acc_out | output | 8 | Accumulator |
| flags_out | output | 3 | {sign, zero, carry} |
| mem_addr | output | 16 | Current H:L |
| mem_we | output | 1 | Memory byte write strobe |
| mem_wdata | output | 8 | Byte to write |

## Verification
The assertions assume that `mem_rdata` returns the byte at `mem_addr` combinationally in the operation cycle. They also assume that a memory operand is never read in the same cycle that its write strobe is high, since the external memory only commits the write at the end of that cycle. The bench models the memory as a combinational array. After every operation that writes the memory byte, it issues an idle cycle, both in the directed cases and in the random mix. Opcodes outside the package list are never driven while `op_valid` is high.

// File: rtl/acc_pkg.sv
package acc_pkg;

  // Low three bits of an arithmetic/logic opcode select the function; bit 3 selects the immediate operand.
  localparam logic [2:0] FN_ADD = 3'd1;
  localparam logic [2:0] FN_SUB = 3'd2;
  localparam logic [2:0] FN_AND = 3'd3;
  localparam logic [2:0] FN_OR  = 3'd4;
  localparam logic [2:0] FN_XOR = 3'd5;
  localparam logic [2:0] FN_CMP = 3'd6;

  typedef enum logic [4:0] {
    OP_NOP   = 5'd0,
    OP_ADD   = 5'd1,
    OP_SUB   = 5'd2,
    OP_AND   = 5'd3,
    OP_OR    = 5'd4,
    OP_XOR   = 5'd5,
    OP_CMP   = 5'd6,
    OP_ADDI  = 5'd9,
    OP_SUBI  = 5'd10,
    OP_ANDI  = 5'd11,
    OP_ORI   = 5'd12,
    OP_XORI  = 5'd13,
    OP_CMPI  = 5'd14,
    OP_INC   = 5'd16,
    OP_DEC   = 5'd17,
    OP_MOVI  = 5'd18,
    OP_ROTL  = 5'd19,
    OP_ROTR  = 5'd20,
    OP_PINC  = 5'd24,
    OP_PDEC  = 5'd25,
    OP_PLOAD = 5'd26,
    OP_PADD  = 5'd27,
    OP_SWAP  = 5'd28
  } op_e;

  localparam logic [2:0] SEL_B = 3'd0;
  localparam logic [2:0] SEL_C = 3'd1;
  localparam logic [2:0] SEL_D = 3'd2;
  localparam logic [2:0] SEL_E = 3'd3;
  localparam logic [2:0] SEL_H = 3'd4;
  localparam logic [2:0] SEL_L = 3'd5;
  localparam logic [2:0] SEL_M = 3'd6;
  localparam logic [2:0] SEL_A = 3'd7;

  localparam logic [1:0] PR_BC = 2'd0;
  localparam logic [1:0] PR_DE = 2'd1;
  localparam logic [1:0] PR_HL = 2'd2;
  localparam logic [1:0] PR_SP = 2'd3;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_S = 2;

endpackage

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [2:0]    fn,
  output logic [DW-1:0] res,
  output logic          cy
);

  logic [DW:0] wide;

  always_comb begin
    wide = '0;
    res  = '0;
    cy   = 1'b0;
    case (fn)
      FN_ADD: begin
        wide = {1'b0, a} + {1'b0, b};
        res  = wide[DW-1:0];
        cy   = wide[DW];
      end
      FN_SUB, FN_CMP: begin
        // bit DW of the extended difference is the borrow
        wide = {1'b0, a} - {1'b0, b};
        res  = wide[DW-1:0];
        cy   = wide[DW];
      end
      FN_AND: res = a & b;
      FN_OR:  res = a | b;
      FN_XOR: res = a ^ b;
      default: res = a;
    endcase
  end

endmodule

// File: rtl/acc_pair16.sv
module acc_pair16 #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic          sub,
  output logic [AW-1:0] res,
  output logic          cy
);

  logic [AW:0] wide;

  always_comb begin
    if (sub) wide = {1'b0, a} - {1'b0, b};
    else     wide = {1'b0, a} + {1'b0, b};
    res = wide[AW-1:0];
    cy  = wide[AW];
  end

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      byte_we,
  input  logic [2:0]                byte_idx,
  input  logic [DW-1:0]             byte_d,
  input  logic                      pair_we,
  input  logic [1:0]                pair_idx,
  input  logic [2*DW-1:0]           pair_d,
  input  logic                      swap,
  output logic [NREG-1:0][DW-1:0]   regs_q,
  output logic [2*DW-1:0]           sp_q
);

  localparam int NPAIR = NREG / 2;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      // D<->H and E<->L trade places on a swap
      localparam int  PARTNER = (i == 2) ? 4 : (i == 3) ? 5 : (i == 4) ? 2 : (i == 5) ? 3 : i;
      localparam int  HALF    = i / 2;
      localparam bit  IS_HI   = (i % 2) == 0;
      logic [DW-1:0] r_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          r_q <= '0;
        end else if (swap && (PARTNER != i)) begin
          r_q <= regs_q[PARTNER];
        end else if (byte_we && (byte_idx == 3'(i))) begin
          r_q <= byte_d;
        end else if (pair_we && (pair_idx == 2'(HALF))) begin
          r_q <= IS_HI ? pair_d[2*DW-1:DW] : pair_d[DW-1:0];
        end
      end

      assign regs_q[i] = r_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                                    sp_q <= '0;
    else if (pair_we && (pair_idx == 2'(NPAIR))) sp_q <= pair_d;
  end

  AST_ONE_WRITE_PORT: assert property (@(posedge clk) disable iff (rst)
    $countones({byte_we, pair_we, swap}) <= 1); // R8

  AST_SWAP_EXCHANGES: assert property (@(posedge clk) disable iff (rst)
    swap |=> (regs_q[4] == $past(regs_q[2])) && (regs_q[2] == $past(regs_q[4]))); // R11

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [4:0]        op_code,
  input  logic [2:0]        op_sel,
  input  logic [1:0]        op_pair,
  input  logic [DW-1:0]     imm8,
  input  logic [2*DW-1:0]   imm16,
  input  logic [DW-1:0]     mem_rdata,
  output logic [DW-1:0]     acc_out,
  output logic [2:0]        flags_out,
  output logic [2*DW-1:0]   mem_addr,
  output logic              mem_we,
  output logic [DW-1:0]     mem_wdata
);

  localparam int AW   = 2 * DW;
  localparam int NREG = 6;

  op_e op;
  assign op = op_e'(op_code);

  logic [DW-1:0]            acc_q;
  logic [2:0]               flags_q;
  logic [NREG-1:0][DW-1:0]  regs_q;
  logic [AW-1:0]            sp_q;
  logic [AW-1:0]            hl;
  logic                     mem_we_q;
  logic [DW-1:0]            mem_wd_q;

  assign hl = {regs_q[4], regs_q[5]};

  // selected byte operand
  logic [DW-1:0] src_byte;
  always_comb begin
    case (op_sel)
      SEL_B:   src_byte = regs_q[0];
      SEL_C:   src_byte = regs_q[1];
      SEL_D:   src_byte = regs_q[2];
      SEL_E:   src_byte = regs_q[3];
      SEL_H:   src_byte = regs_q[4];
      SEL_L:   src_byte = regs_q[5];
      SEL_M:   src_byte = mem_rdata;
      default: src_byte = acc_q;
    endcase
  end

  // selected pair operand
  logic [AW-1:0] pair_val;
  always_comb begin
    case (op_pair)
      PR_BC:   pair_val = {regs_q[0], regs_q[1]};
      PR_DE:   pair_val = {regs_q[2], regs_q[3]};
      PR_HL:   pair_val = hl;
      default: pair_val = sp_q;
    endcase
  end

  // byte ALU
  logic [DW-1:0] alu_b, alu_res;
  logic          alu_cy;
  assign alu_b = op_code[3] ? imm8 : src_byte;

  acc_alu8 #(.DW(DW)) u_alu (
    .a   (acc_q),
    .b   (alu_b),
    .fn  (op_code[2:0]),
    .res (alu_res),
    .cy  (alu_cy)
  );

  // in-place step
  logic [DW-1:0] step_res;
  assign step_res = (op == OP_DEC) ? (src_byte - DW'(1)) : (src_byte + DW'(1));

  // pair arithmetic
  logic [AW-1:0] pu_a, pu_b, pu_res;
  logic          pu_sub, pu_cy;
  assign pu_a   = (op == OP_PADD) ? hl : pair_val;
  assign pu_b   = (op == OP_PADD) ? pair_val : AW'(1);
  assign pu_sub = (op == OP_PDEC);

  acc_pair16 #(.AW(AW)) u_pair (
    .a   (pu_a),
    .b   (pu_b),
    .sub (pu_sub),
    .res (pu_res),
    .cy  (pu_cy)
  );

  // control and next-state selection
  logic           acc_en, flags_en, dest_wr;
  logic [DW-1:0]  acc_d, dest_val;
  logic [2:0]     flags_d;
  logic           rb_we, rp_we, do_swap, mw_en;
  logic [1:0]     rp_idx;
  logic [AW-1:0]  rp_d;

  assign dest_val = (op == OP_MOVI) ? imm8 : step_res;

  always_comb begin
    acc_en   = 1'b0;
    acc_d    = acc_q;
    flags_en = 1'b0;
    flags_d  = flags_q;
    dest_wr  = 1'b0;
    rp_we    = 1'b0;
    rp_idx   = op_pair;
    rp_d     = pu_res;
    do_swap  = 1'b0;
    if (op_valid) begin
      case (op)
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_CMP,
        OP_ADDI, OP_SUBI, OP_ANDI, OP_ORI, OP_XORI, OP_CMPI: begin
          flags_en = 1'b1;
          flags_d  = {alu_res[DW-1], (alu_res == '0), alu_cy};
          if (op_code[2:0] != FN_CMP) begin
            acc_en = 1'b1;
            acc_d  = alu_res;
          end
        end
        OP_INC, OP_DEC: begin
          dest_wr  = 1'b1;
          flags_en = 1'b1;
          flags_d  = {step_res[DW-1], (step_res == '0), flags_q[FLAG_C]};
        end
        OP_MOVI: dest_wr = 1'b1;
        OP_ROTL: begin
          acc_en   = 1'b1;
          acc_d    = {acc_q[DW-2:0], acc_q[DW-1]};
          flags_en = 1'b1;
          flags_d  = {flags_q[FLAG_S], flags_q[FLAG_Z], acc_q[DW-1]};
        end
        OP_ROTR: begin
          acc_en   = 1'b1;
          acc_d    = {acc_q[0], acc_q[DW-1:1]};
          flags_en = 1'b1;
          flags_d  = {flags_q[FLAG_S], flags_q[FLAG_Z], acc_q[0]};
        end
        OP_PINC, OP_PDEC: rp_we = 1'b1;
        OP_PLOAD: begin
          rp_we = 1'b1;
          rp_d  = imm16;
        end
        OP_PADD: begin
          rp_we    = 1'b1;
          rp_idx   = PR_HL;
          flags_en = 1'b1;
          flags_d  = {flags_q[FLAG_S], flags_q[FLAG_Z], pu_cy};
        end
        OP_SWAP: do_swap = 1'b1;
        default: ;
      endcase
      if (dest_wr && (op_sel == SEL_A)) begin
        acc_en = 1'b1;
        acc_d  = dest_val;
      end
    end
  end

  assign rb_we = dest_wr && (op_sel != SEL_A) && (op_sel != SEL_M);
  assign mw_en = dest_wr && (op_sel == SEL_M);

  acc_regfile #(.DW(DW), .NREG(NREG)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .byte_we  (rb_we),
    .byte_idx (op_sel),
    .byte_d   (dest_val),
    .pair_we  (rp_we),
    .pair_idx (rp_idx),
    .pair_d   (rp_d),
    .swap     (do_swap),
    .regs_q   (regs_q),
    .sp_q     (sp_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      flags_q  <= '0;
      mem_we_q <= 1'b0;
      mem_wd_q <= '0;
    end else begin
      if (acc_en)   acc_q   <= acc_d;
      if (flags_en) flags_q <= flags_d;
      mem_we_q <= mw_en;
      if (mw_en) mem_wd_q <= dest_val;
    end
  end

  assign acc_out   = acc_q;
  assign flags_out = flags_q;
  assign mem_addr  = hl;
  assign mem_we    = mem_we_q;
  assign mem_wdata = mem_wd_q;

  AST_CMP_HOLDS_ACC: assert property (@(posedge clk) disable iff (rst)
    (op_valid && ((op == OP_CMP) || (op == OP_CMPI))) |=> $stable(acc_out)); // R3

  AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_valid && ((op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
                  (op == OP_ANDI) || (op == OP_ORI) || (op == OP_XORI)))
    |=> !flags_out[FLAG_C]); // R4

  AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_valid && ((op == OP_INC) || (op == OP_DEC))) |=> $stable(flags_out[FLAG_C])); // R6

  AST_PAIR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && ((op == OP_PINC) || (op == OP_PDEC) || (op == OP_PLOAD) || (op == OP_SWAP)))
    |=> $stable(flags_out)); // R8

  AST_WE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(op_valid && (op_sel == SEL_M) &&
                     ((op == OP_INC) || (op == OP_DEC) || (op == OP_MOVI)))); // R12

  AST_WE_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $stable(mem_addr)); // R12

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(acc_out) && $stable(flags_out) && $stable(mem_addr) && !mem_we)); // R13

endmodule

// File: tb/test_acc_datapath.sv
`timescale 1ns/1ps
module test_acc_datapath;
  import acc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = 5'd0;
  logic [2:0]  op_sel = 3'd0;
  logic [1:0]  op_pair = 2'd0;
  logic [7:0]  imm8 = 8'd0;
  logic [15:0] imm16 = 16'd0;
  logic [7:0]  mem_rdata;
  logic [7:0]  acc_out;
  logic [2:0]  flags_out;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;

  always #10 clk = ~clk;

  logic [7:0] ram [0:255];
  assign mem_rdata = ram[mem_addr[7:0]];

  acc_datapath i_acc_datapath (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_sel(op_sel),
    .op_pair(op_pair), .imm8(imm8), .imm16(imm16), .mem_rdata(mem_rdata),
    .acc_out(acc_out), .flags_out(flags_out), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";

  // reference state
  logic [7:0]  ma;
  logic [7:0]  mr [0:5];
  logic [15:0] msp;
  logic        ms, mz, mc, mwe;
  logic [7:0]  mwd;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("acc", acc_out, ma);
    chk("flags", flags_out, {ms, mz, mc});
    chk("addr", mem_addr, {mr[4], mr[5]});
    chk("we", mem_we, mwe);
    if (mwe) chk("wdata", mem_wdata, mwd);
  endtask

  function automatic logic [15:0] mget_pair(logic [1:0] p);
    case (p)
      2'd0: return {mr[0], mr[1]};
      2'd1: return {mr[2], mr[3]};
      2'd2: return {mr[4], mr[5]};
      default: return msp;
    endcase
  endfunction

  task automatic mset_pair(logic [1:0] p, logic [15:0] v);
    case (p)
      2'd0: begin mr[0] = v[15:8]; mr[1] = v[7:0]; end
      2'd1: begin mr[2] = v[15:8]; mr[3] = v[7:0]; end
      2'd2: begin mr[4] = v[15:8]; mr[5] = v[7:0]; end
      default: msp = v;
    endcase
  endtask

  task automatic model(logic v, logic [4:0] op, logic [2:0] s, logic [1:0] p,
                       logic [7:0] i8, logic [15:0] i16);
    logic [7:0]  sv, opnd, r;
    logic [8:0]  t;
    logic [16:0] t16;
    logic [15:0] hl;
    hl  = {mr[4], mr[5]};
    sv  = (s == 3'd7) ? ma : (s == 3'd6) ? ram[hl[7:0]] : mr[s];
    mwe = 1'b0;
    if (v) begin
      opnd = op[3] ? i8 : sv;
      case (op)
        OP_ADD, OP_ADDI: begin t = {1'b0, ma} + {1'b0, opnd}; ma = t[7:0]; mc = t[8]; ms = ma[7]; mz = (ma == 0); end
        OP_SUB, OP_SUBI: begin mc = (opnd > ma); ma = ma - opnd; ms = ma[7]; mz = (ma == 0); end
        OP_CMP, OP_CMPI: begin mc = (opnd > ma); r = ma - opnd; ms = r[7]; mz = (r == 0); end
        OP_AND, OP_ANDI: begin ma = ma & opnd; mc = 0; ms = ma[7]; mz = (ma == 0); end
        OP_OR,  OP_ORI:  begin ma = ma | opnd; mc = 0; ms = ma[7]; mz = (ma == 0); end
        OP_XOR, OP_XORI: begin ma = ma ^ opnd; mc = 0; ms = ma[7]; mz = (ma == 0); end
        OP_INC, OP_DEC, OP_MOVI: begin
          if (op == OP_MOVI) r = i8;
          else begin
            r = (op == OP_INC) ? sv + 8'd1 : sv - 8'd1;
            ms = r[7]; mz = (r == 0);
          end
          if (s == 3'd7) ma = r;
          else if (s == 3'd6) begin ram[hl[7:0]] = r; mwe = 1'b1; mwd = r; end
          else mr[s] = r;
        end
        OP_ROTL: begin mc = ma[7]; ma = {ma[6:0], ma[7]}; end
        OP_ROTR: begin mc = ma[0]; ma = {ma[0], ma[7:1]}; end
        OP_PINC:  mset_pair(p, mget_pair(p) + 16'd1);
        OP_PDEC:  mset_pair(p, mget_pair(p) - 16'd1);
        OP_PLOAD: mset_pair(p, i16);
        OP_PADD: begin t16 = {1'b0, hl} + {1'b0, mget_pair(p)}; mc = t16[16]; mset_pair(2'd2, t16[15:0]); end
        OP_SWAP: begin r = mr[2]; mr[2] = mr[4]; mr[4] = r; r = mr[3]; mr[3] = mr[5]; mr[5] = r; end
        default: ;
      endcase
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic do_op(logic v, logic [4:0] op, logic [2:0] s, logic [1:0] p,
                       logic [7:0] i8, logic [15:0] i16);
    op_valid = v; op_code = op; op_sel = s; op_pair = p; imm8 = i8; imm16 = i16;
    @(posedge clk);
    @(negedge clk);
    model(v, op, s, p, i8, i16);
    compare_all();
  endtask

  task automatic run(logic [4:0] op, logic [2:0] s, logic [7:0] i8);
    do_op(1'b1, op, s, 2'd0, i8, 16'h0);
  endtask

  task automatic prun(logic [4:0] op, logic [1:0] p, logic [15:0] i16);
    do_op(1'b1, op, 3'd0, p, 8'h0, i16);
  endtask

  task automatic idle();
    do_op(1'b0, 5'd0, 3'd0, 2'd0, 8'h0, 16'h0);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) ram[k] = 8'(k * 7 + 3);
    ma = 0; msp = 0; ms = 0; mz = 0; mc = 0; mwe = 0; mwd = 0;
    for (int k = 0; k < 6; k++) mr[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cur_req = "R1"; compare_all();
    run(OP_ADD, SEL_B, 8'h0); run(OP_ADD, SEL_L, 8'h0);
    prun(OP_PADD, PR_SP, 16'h0);

    cur_req = "R7";
    run(OP_MOVI, SEL_B, 8'h11); run(OP_MOVI, SEL_C, 8'h22); run(OP_MOVI, SEL_D, 8'h33);
    run(OP_MOVI, SEL_E, 8'h44); run(OP_MOVI, SEL_H, 8'h00); run(OP_MOVI, SEL_L, 8'h40);
    run(OP_MOVI, SEL_A, 8'h05);
    cur_req = "R12";
    run(OP_MOVI, SEL_M, 8'h5A); idle();

    cur_req = "R2";
    run(OP_ADD, SEL_B, 0); run(OP_ADD, SEL_M, 0); run(OP_SUB, SEL_C, 0);
    run(OP_XOR, SEL_D, 0); run(OP_OR, SEL_E, 0); run(OP_AND, SEL_L, 0);
    run(OP_ADD, SEL_A, 0); run(OP_SUB, SEL_A, 0);

    cur_req = "R4";
    run(OP_MOVI, SEL_A, 8'hF0); run(OP_MOVI, SEL_B, 8'h20); run(OP_ADD, SEL_B, 0);
    run(OP_MOVI, SEL_A, 8'h80); run(OP_MOVI, SEL_B, 8'h80); run(OP_ADD, SEL_B, 0);
    run(OP_MOVI, SEL_B, 8'h01); run(OP_SUB, SEL_B, 0);
    run(OP_OR, SEL_B, 0);
    run(OP_MOVI, SEL_A, 8'h7F); run(OP_ADDI, SEL_A, 8'h01);

    cur_req = "R3";
    run(OP_MOVI, SEL_A, 8'h40); run(OP_MOVI, SEL_C, 8'h40); run(OP_CMP, SEL_C, 0);
    run(OP_MOVI, SEL_C, 8'h41); run(OP_CMP, SEL_C, 0);
    run(OP_CMPI, SEL_A, 8'h10); run(OP_CMP, SEL_M, 0);

    cur_req = "R5";
    run(OP_ADDI, SEL_A, 8'hC5); run(OP_SUBI, SEL_A, 8'h33); run(OP_ANDI, SEL_A, 8'h5F);
    run(OP_ORI, SEL_A, 8'h80); run(OP_XORI, SEL_A, 8'hFF); run(OP_SUBI, SEL_A, 8'hEE);

    cur_req = "R6";
    run(OP_MOVI, SEL_D, 8'hFF); run(OP_INC, SEL_D, 0); run(OP_ADD, SEL_D, 0);
    run(OP_DEC, SEL_D, 0); run(OP_INC, SEL_A, 0); run(OP_DEC, SEL_A, 0);
    cur_req = "R12";
    run(OP_INC, SEL_M, 0); idle(); run(OP_ADD, SEL_M, 0);
    run(OP_DEC, SEL_M, 0); idle(); run(OP_DEC, SEL_M, 0); idle();

    cur_req = "R10";
    run(OP_MOVI, SEL_A, 8'h81); run(OP_ROTL, SEL_A, 0); run(OP_ROTL, SEL_A, 0);
    run(OP_ROTR, SEL_A, 0); run(OP_ROTR, SEL_A, 0); run(OP_ROTR, SEL_A, 0);

    cur_req = "R8";
    prun(OP_PLOAD, PR_BC, 16'h1234); prun(OP_PLOAD, PR_DE, 16'hABCD);
    prun(OP_PLOAD, PR_SP, 16'hFFFF); prun(OP_PLOAD, PR_HL, 16'h00FF);
    prun(OP_PINC, PR_HL, 0); prun(OP_PDEC, PR_HL, 0);
    prun(OP_PINC, PR_SP, 0); prun(OP_PDEC, PR_SP, 0); prun(OP_PDEC, PR_SP, 0);
    prun(OP_PINC, PR_BC, 0); prun(OP_PDEC, PR_DE, 0);
    run(OP_MOVI, SEL_A, 0); run(OP_ADD, SEL_B, 0); run(OP_ADD, SEL_C, 0);

    cur_req = "R9";
    prun(OP_PLOAD, PR_HL, 16'h0000); prun(OP_PADD, PR_BC, 0);
    prun(OP_PADD, PR_SP, 0); prun(OP_PADD, PR_HL, 0); prun(OP_PADD, PR_DE, 0);
    prun(OP_PLOAD, PR_HL, 16'h0001); prun(OP_PADD, PR_SP, 0);

    cur_req = "R11";
    prun(OP_PLOAD, PR_HL, 16'h0077); prun(OP_SWAP, PR_BC, 0);
    run(OP_MOVI, SEL_A, 0); run(OP_ADD, SEL_E, 0); prun(OP_SWAP, PR_BC, 0);

    cur_req = "R13";
    do_op(1'b0, OP_MOVI, SEL_M, PR_HL, 8'hEE, 16'h9999);
    do_op(1'b0, OP_PLOAD, SEL_A, PR_HL, 8'hEE, 16'h9999);
    do_op(1'b0, OP_ADDI, SEL_A, PR_SP, 8'h7E, 16'h0);
    run(OP_ADD, SEL_A, 0);

    cur_req = "R2";
    begin
      logic [4:0] oplist [0:22];
      oplist = '{OP_NOP, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_CMP, OP_ADDI, OP_SUBI,
                 OP_ANDI, OP_ORI, OP_XORI, OP_CMPI, OP_INC, OP_DEC, OP_MOVI, OP_ROTL,
                 OP_ROTR, OP_PINC, OP_PDEC, OP_PLOAD, OP_PADD, OP_SWAP};
      for (int n = 0; n < 600; n++) begin
        logic [4:0] o;
        logic [2:0] s;
        o = oplist[$urandom_range(0, 22)];
        s = 3'($urandom_range(0, 7));
        do_op(($urandom_range(0, 7) != 0), o, s, 2'($urandom_range(0, 3)),
              8'($urandom), 16'($urandom));
        if (mwe) idle();
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule